// File: doc/BRIEF.md
# Two-Level Cached Priority Queue

This block stores prioritised elements and always presents the one with the lowest priority value at its head. Each element is a priority word paired with an identifier word. Storage is split into two levels. A small front level is a sorted register array, and it answers every head query with no delay. A larger back level is a binary min-heap held in a single-port RAM. The heap root sits at address 0, and the children of entry i sit at addresses 2i+1 and 2i+2.

A user inserts by pulsing `ins_en` with a priority and identifier. A user removes by pulsing `rem_en` after reading the head outputs. Both pulses are honoured only while `ready` is high. Most traffic touches only the front array: inserting a small value, or removing the head, finishes in one cycle. The RAM heap is used only when the front overflows, when the front falls below a low-water mark, or when a new element belongs behind the heap root. While the heap is being repaired, one RAM read or write per cycle, `ready` is low.

Top module: `tiered_pq`

## Requirements
- R1: After reset, `ready` is 1, `empty` is 1, `full` is 0, `count` is 0 and `head_valid` is 0.
- R2: Whenever `ready` is 1 and `count` is nonzero, `head_valid` is 1. The head outputs then show the lowest stored priority and the identifier inserted with it. Holding the inputs idle leaves the head unchanged.
- R3: An accepted remove takes out exactly the element shown at the head. Successive removals come out in nondecreasing priority order, and every accepted insert comes out exactly once.
- R4: Inputs are accepted only while `ready` is 1. An insert while `full` is 1 is ignored. A remove while `empty` is 1 is ignored. When `ins_en` and `rem_en` are high in the same cycle, only the insert is performed.
- R5: An insert accepted while the front array has room and the heap is empty completes in that cycle, and `ready` is still 1 in the next cycle. The same holds for a remove accepted while the heap is empty.
- R6: An insert accepted while the front array holds FRONT_DEPTH entries pushes the largest candidate into the heap, and `ready` is 0 in the next cycle.
- R7: `count` equals the number of stored elements. It rises by 1 per accepted insert and falls by 1 per accepted remove. `full` is 1 exactly when `count` equals FRONT_DEPTH+HEAP_DEPTH, and `empty` is 1 exactly when `count` is 0.
- R8: If a removal leaves fewer than LOW_MARK entries in the front while the heap is not empty, heap roots are moved into the front and the heap is repaired. This repeats until the mark is reached or the heap is empty. Whenever `ready` is 1 and the heap is not empty, the front holds at least LOW_MARK entries.
- R9: An insert whose priority exceeds the heap root, accepted while the front has room, causes an exchange. The root moves to the front, and the new element enters the heap at the root position and sinks down. Whenever `ready` is 1, no front entry has a priority above the heap root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert request |
| ins_prio | input | PW | Priority of the element to insert |
| ins_id | input | IW | Identifier of the element to insert |
| rem_en | input | 1 | Remove-head request |
| ready | output | 1 | Block accepts a request this cycle |
| head_valid | output | 1 | Head outputs hold a stored element |
| head_prio | output | PW | Lowest stored priority |
| head_id | output | IW | Identifier paired with the head priority |
| full | output | 1 | Both levels are full |
| empty | output | 1 | Nothing is stored |
| count | output | $clog2(FRONT_DEPTH+HEAP_DEPTH+1) | Number of stored elements |

## Verification
The assertions check the following on every cycle:
- count steps exactly with accepted inserts;
- rejected inserts when full and rejected removes when empty leave count unchanged;
- the fast-path and spill behaviour of `ready`;
- the low-water occupancy of the front, and the ordering between the front's largest entry and the heap root, whenever the block is idle.

Only the bench's scenarios can show that the elements leaving the queue are the right ones, in the right order, with the right identifiers. It covers spills, exchanges, refills, a full queue, simultaneous requests and a long mixed sequence with duplicate priorities.

// File: rtl/tiered_pq.sv
module tiered_pq #(
  parameter int PW = 32,
  parameter int IW = 32,
  parameter int FRONT_DEPTH = 4,
  parameter int HEAP_DEPTH = 16,
  parameter int LOW_MARK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ins_en,
  input  logic [PW-1:0] ins_prio,
  input  logic [IW-1:0] ins_id,
  input  logic rem_en,
  output logic ready,
  output logic head_valid,
  output logic [PW-1:0] head_prio,
  output logic [IW-1:0] head_id,
  output logic full,
  output logic empty,
  output logic [$clog2(FRONT_DEPTH+HEAP_DEPTH+1)-1:0] count
);
  localparam int EW = PW + IW;
  localparam int AW = $clog2(HEAP_DEPTH);
  localparam int HW = $clog2(HEAP_DEPTH + 1);
  localparam int FW = $clog2(FRONT_DEPTH + 1);
  localparam int XW = HW + 1;
  localparam int CW = $clog2(FRONT_DEPTH + HEAP_DEPTH + 1);
  localparam logic [FW-1:0] FD = FW'(FRONT_DEPTH);
  localparam logic [FW-1:0] LM = FW'(LOW_MARK);
  localparam logic [CW-1:0] CAP = CW'(FRONT_DEPTH + HEAP_DEPTH);

  typedef enum logic [3:0] {S_IDLE, S_UP_RD, S_UP_CMP, S_DN_LAST, S_DN_GET,
                            S_DN_L, S_DN_R, S_DN_CMP, S_RT_RD, S_RT_GET} st_t;

  function automatic logic [PW-1:0] pr(input logic [EW-1:0] v);
    return v[EW-1 -: PW];
  endfunction

  st_t st;
  logic [EW-1:0] fe [FRONT_DEPTH];
  logic [EW-1:0] fe_ins [FRONT_DEPTH];
  logic [EW-1:0] mem [HEAP_DEPTH];
  logic [EW-1:0] rd, e, lc, root_q, evict, xin, cand;
  logic [FW-1:0] fcnt;
  logic [HW-1:0] hcnt;
  logic [XW-1:0] idx, par, lx, rx, hc, cidx;
  logic hasr, do_ins, do_rem, to_heap, sink;
  logic mem_we, mem_re;
  logic [AW-1:0] mem_a;
  logic [EW-1:0] mem_wd;
  logic [PW-1:0] front_max_prio, root_prio;
  int pos;

  assign xin = {ins_prio, ins_id};
  assign ready = (st == S_IDLE);
  assign count = CW'(fcnt) + CW'(hcnt);
  assign full = (count == CAP);
  assign empty = (count == '0);
  assign head_valid = (fcnt != '0);
  assign head_prio = pr(fe[0]);
  assign head_id = fe[0][IW-1:0];
  assign root_prio = pr(root_q);
  assign do_ins = ready && ins_en && !full;
  assign do_rem = ready && rem_en && !ins_en && !empty;
  assign to_heap = (hcnt != '0) && (ins_prio > pr(root_q));
  assign par = (idx - XW'(1)) >> 1;
  assign lx = {idx[XW-2:0], 1'b1};
  assign rx = lx + XW'(1);
  assign hc = XW'(hcnt);
  assign cand = (hasr && pr(rd) < pr(lc)) ? rd : lc;
  assign cidx = (hasr && pr(rd) < pr(lc)) ? rx : lx;
  assign sink = pr(cand) < pr(e);

  always_comb begin
    pos = 0;
    front_max_prio = '0;
    for (int j = 0; j < FRONT_DEPTH; j++) begin
      if (j < int'(fcnt) && pr(fe[j]) <= ins_prio) pos = pos + 1;
      if (j == int'(fcnt) - 1) front_max_prio = pr(fe[j]);
    end
    for (int j = 0; j < FRONT_DEPTH; j++) begin
      if (j < pos) fe_ins[j] = fe[j];
      else if (j == pos) fe_ins[j] = xin;
      else fe_ins[j] = (j > 0) ? fe[(j > 0) ? j - 1 : 0] : xin;
    end
    evict = (pos == FRONT_DEPTH) ? xin : fe[FRONT_DEPTH-1];
  end

  always_comb begin
    mem_we = 1'b0;
    mem_re = 1'b0;
    mem_a = '0;
    mem_wd = e;
    case (st)
      S_UP_RD:  if (idx == '0) mem_we = 1'b1;
                else begin mem_re = 1'b1; mem_a = AW'(par); end
      S_UP_CMP: begin
        mem_we = 1'b1; mem_a = AW'(idx);
        mem_wd = (pr(rd) > pr(e)) ? rd : e;
      end
      S_DN_LAST: begin mem_re = 1'b1; mem_a = AW'(hcnt); end
      S_DN_L:   if (lx >= hc) begin mem_we = 1'b1; mem_a = AW'(idx); end
                else begin mem_re = 1'b1; mem_a = AW'(lx); end
      S_DN_R:   if (rx < hc) begin mem_re = 1'b1; mem_a = AW'(rx); end
      S_DN_CMP: begin
        mem_we = 1'b1; mem_a = AW'(idx);
        mem_wd = sink ? cand : e;
      end
      S_RT_RD:  mem_re = (hcnt != '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_a] <= mem_wd;
    if (mem_re) rd <= mem[mem_a];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fcnt <= '0;
      hcnt <= '0;
      idx <= '0;
      e <= '0;
      lc <= '0;
      hasr <= 1'b0;
      root_q <= '0;
      for (int j = 0; j < FRONT_DEPTH; j++) fe[j] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (do_ins) begin
            if (to_heap && fcnt < FD) begin
              for (int j = 0; j < FRONT_DEPTH; j++) if (j == int'(fcnt)) fe[j] <= root_q;
              fcnt <= fcnt + FW'(1);
              e <= xin;
              idx <= '0;
              st <= S_DN_L;
            end else if (to_heap) begin
              e <= xin;
              idx <= XW'(hcnt);
              hcnt <= hcnt + HW'(1);
              st <= S_UP_RD;
            end else begin
              for (int j = 0; j < FRONT_DEPTH; j++) fe[j] <= fe_ins[j];
              if (fcnt < FD) fcnt <= fcnt + FW'(1);
              else begin
                e <= evict;
                idx <= XW'(hcnt);
                hcnt <= hcnt + HW'(1);
                st <= S_UP_RD;
              end
            end
          end else if (do_rem) begin
            for (int j = 0; j < FRONT_DEPTH - 1; j++) fe[j] <= fe[j+1];
            fcnt <= fcnt - FW'(1);
            if (hcnt != '0 && int'(fcnt) - 1 < LOW_MARK) st <= S_RT_RD;
          end
        S_UP_RD:  st <= (idx == '0) ? S_RT_RD : S_UP_CMP;
        S_UP_CMP:
          if (pr(rd) > pr(e)) begin idx <= par; st <= S_UP_RD; end
          else st <= S_RT_RD;
        S_DN_LAST: st <= S_DN_GET;
        S_DN_GET: begin e <= rd; idx <= '0; st <= S_DN_L; end
        S_DN_L:   st <= (lx >= hc) ? S_RT_RD : S_DN_R;
        S_DN_R:   begin lc <= rd; hasr <= (rx < hc); st <= S_DN_CMP; end
        S_DN_CMP:
          if (sink) begin idx <= cidx; st <= S_DN_L; end
          else st <= S_RT_RD;
        S_RT_RD:  st <= (hcnt == '0) ? S_IDLE : S_RT_GET;
        S_RT_GET: begin
          root_q <= rd;
          if (fcnt < LM) begin
            for (int j = 0; j < FRONT_DEPTH; j++) if (j == int'(fcnt)) fe[j] <= rd;
            fcnt <= fcnt + FW'(1);
            hcnt <= hcnt - HW'(1);
            st <= (hcnt == HW'(1)) ? S_IDLE : S_DN_LAST;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tiered_pq_chk.sv
module tiered_pq_chk #(
  parameter int PW = 32,
  parameter int FRONT_DEPTH = 4,
  parameter int HEAP_DEPTH = 16,
  parameter int LOW_MARK = 2,
  parameter int FW = $clog2(FRONT_DEPTH + 1),
  parameter int HW = $clog2(HEAP_DEPTH + 1),
  parameter int CW = $clog2(FRONT_DEPTH + HEAP_DEPTH + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic ins_en,
  input logic rem_en,
  input logic ready,
  input logic head_valid,
  input logic full,
  input logic empty,
  input logic [CW-1:0] count,
  input logic [FW-1:0] fcnt,
  input logic [HW-1:0] hcnt,
  input logic [PW-1:0] front_max_prio,
  input logic [PW-1:0] root_prio
);
  localparam logic [FW-1:0] FD = FW'(FRONT_DEPTH);
  localparam logic [FW-1:0] LM = FW'(LOW_MARK);

  p_head_shown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (head_valid == !empty));

  p_full_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ins_en && full) |=> (count == $past(count)));

  p_empty_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rem_en && !ins_en && empty) |=> (count == $past(count)));

  p_fast_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ins_en && !full && fcnt < FD && hcnt == '0) |=> ready);

  p_fast_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rem_en && !ins_en && !empty && hcnt == '0) |=> ready);

  p_spill_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ins_en && !full && fcnt == FD) |=> !ready);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ins_en && !full) |=> (count == $past(count) + CW'(1)));

  p_low_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && hcnt != '0) |-> (fcnt >= LM));

  p_levels_ordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && hcnt != '0) |-> (front_max_prio <= root_prio));
endmodule

bind tiered_pq tiered_pq_chk #(
  .PW(PW), .FRONT_DEPTH(FRONT_DEPTH), .HEAP_DEPTH(HEAP_DEPTH), .LOW_MARK(LOW_MARK)
) u_chk (.*);

// File: tb/sim_tiered_pq.sv
module sim_tiered_pq;
  localparam int CAP = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_en = 1'b0;
  logic rem_en = 1'b0;
  logic [31:0] ins_prio = '0;
  logic [31:0] ins_id = '0;
  logic ready, head_valid, full, empty;
  logic [31:0] head_prio, head_id;
  logic [4:0] count;

  int nrun = 0;
  int nfail = 0;
  bit done = 1'b0;
  int unsigned model[$];
  int unsigned expq[$];
  int unsigned ep;
  bit r;

  tiered_pq u0 (.clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_prio(ins_prio),
    .ins_id(ins_id), .rem_en(rem_en), .ready(ready), .head_valid(head_valid),
    .head_prio(head_prio), .head_id(head_id), .full(full), .empty(empty), .count(count));

  always #5 clk = ~clk;

  function automatic logic [31:0] idf(input logic [31:0] p);
    return p * 32'd3 + 32'd7;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_add(input int unsigned p);
    int i = 0;
    while (i < model.size() && model[i] <= p) i++;
    model.insert(i, p);
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
  endtask

  task automatic put(input int unsigned p, output bit rdy_after);
    wait_idle();
    ins_en = 1'b1; ins_prio = p; ins_id = idf(p);
    if (model.size() < CAP) model_add(p);
    @(negedge clk);
    ins_en = 1'b0;
    rdy_after = ready;
  endtask

  task automatic take(output bit rdy_after);
    wait_idle();
    if (model.size() > 0) begin
      check(head_valid == 1'b1, "R2", "head_valid before remove", head_valid, 1);
      expq.push_back(model.pop_front());
    end
    rem_en = 1'b1;
    @(negedge clk);
    rem_en = 1'b0;
    rdy_after = ready;
  endtask

  task automatic drain(input string tag);
    bit rr;
    while (model.size() > 0) take(rr);
    wait_idle();
    check(empty == 1'b1 && count == 0, "R7", {tag, " empty after drain"}, count, 0);
    check(expq.size() == 0, "R3", {tag, " removals outstanding"}, expq.size(), 0);
  endtask

  always @(posedge clk) begin
    if (rst_n && ready && rem_en && !ins_en && head_valid) begin
      if (expq.size() == 0) check(1'b0, "R3", "unexpected removal", head_prio, 0);
      else begin
        ep = expq.pop_front();
        check(head_prio == ep && head_id == idf(ep), "R3", "removed priority", head_prio, ep);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && empty && !full && count == 0 && !head_valid, "R1", "reset state",
          {ready, empty, full, head_valid}, 4'b1100);

    put(50, r); check(r, "R5", "fast insert ready", r, 1);
    put(20, r); check(r, "R5", "fast insert ready", r, 1);
    put(80, r); check(r, "R5", "fast insert ready", r, 1);
    check(head_prio == 20 && head_id == idf(20), "R2", "head is minimum", head_prio, 20);
    repeat (3) @(negedge clk);
    check(head_prio == 20 && count == 3, "R2", "head stable while idle", head_prio, 20);
    put(10, r);
    take(r); check(r, "R5", "fast remove ready", r, 1);
    check(count == 3, "R7", "count after insert+remove", count, 3);

    put(30, r);
    put(5, r); check(!r, "R6", "spill makes busy", r, 0);
    wait_idle();
    check(head_prio == 5 && count == 5, "R2", "head after spill", head_prio, 5);
    put(90, r);
    put(60, r);
    wait_idle();
    check(count == 7, "R7", "count after heap inserts", count, 7);
    drain("R8 refill");

    put(100, r); put(200, r); put(300, r); put(400, r); put(500, r); put(600, r);
    take(r); take(r);
    wait_idle();
    check(head_prio == 300, "R8", "head after removes", head_prio, 300);
    put(700, r); check(!r, "R9", "exchange makes busy", r, 0);
    wait_idle();
    check(head_prio == 300 && count == 5, "R9", "head after exchange", head_prio, 300);
    put(350, r);
    drain("R9 exchange");

    for (int i = 0; i < CAP; i++) put((i * 37) % 101 + 200, r);
    wait_idle();
    check(full == 1'b1 && count == CAP, "R7", "full at capacity", count, CAP);
    put(1, r);
    wait_idle();
    check(count == CAP && head_prio == model[0], "R4", "insert while full ignored", head_prio, model[0]);
    drain("R4 full");

    take(r);
    wait_idle();
    check(count == 0 && empty == 1'b1, "R4", "remove while empty ignored", count, 0);

    put(10, r); put(20, r);
    wait_idle();
    ins_en = 1'b1; rem_en = 1'b1; ins_prio = 15; ins_id = idf(15);
    model_add(15);
    @(negedge clk);
    ins_en = 1'b0; rem_en = 1'b0;
    wait_idle();
    check(count == 3 && head_prio == 10, "R4", "simultaneous insert wins", count, 3);
    drain("R4 simultaneous");

    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if ((lf[1:0] != 2'b00 || model.size() == 0) && model.size() < CAP) put(32'(lf[11:6]), r);
        else take(r);
      end
    end
    wait_idle();
    check(count == model.size(), "R7", "count after stress", count, model.size());
    drain("R3 stress");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule